// File: doc/BRIEF.md
# Modulo Bit-Reversing Address Generator

This block generates data-memory addresses for indirect accesses, in the way a DSP core does. It holds three small register files of equal size: index registers, modify registers and length registers. On each access request the block puts the selected index register on the address output. It then post-modifies that index by adding the selected modify register, which holds a signed value. The index and modify selections are made independently of each other.

When the length register paired with the selected index is non-zero, the updated index wraps so that it stays inside a circular buffer. The buffer starts on a power-of-two boundary. With a length of zero the add is plain linear arithmetic, modulo 2^14. A mode input can present the emitted address bit-reversed, as FFT addressing needs. The reversal never changes the value written back to the index register. A host port reads and writes every register.

Top module: `dag_addr_gen`

## Requirements
- R1: After reset every index, modify and length register reads as zero, and `addr_valid` is low.
- R2: Host writes take effect at the next clock edge. `host_rdata` shows the addressed register combinationally. The file codes are 0 for index, 1 for modify and 2 for length. Code 3 reads as zero and a write with code 3 changes nothing.
- R3: For a request sampled at a clock edge, `addr_valid` is high in the following cycle. In that cycle `addr` holds the selected index value as it was before the update.
- R4: After a request, the selected index equals the old index plus the selected modify register. The modify value is treated as two's-complement signed.
- R5: Any index register may be paired with any modify register. Index registers that are not selected keep their values.
- R6: When length register n (paired with index n) is zero, the update is a 14-bit add that wraps modulo 2^14.
- R7: When the length L is non-zero, the buffer base is the index with its low k bits cleared, where 2^k is the smallest power of two that is at least L. If the sum exceeds base+L-1, L is subtracted from it. If the sum is below base, L is added to it.
- R8: When `brev_en` is high with a request, `addr` carries the old index with its bit order reversed (bit 0 swaps with bit 13, and so on). The stored index still takes the normal update.
- R9: When a host write to an index register and a request that updates the same register fall in the same cycle, the host data is stored. The emitted address is still the old index.
- R10: Requests on consecutive cycles each see the index value left by the previous update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request |
| req_isel | input | 2 | Index register select |
| req_msel | input | 2 | Modify register select |
| brev_en | input | 1 | Bit-reverse the emitted address |
| addr_valid | output | 1 | Address output is valid |
| addr | output | 14 | Emitted memory address |
| host_we | input | 1 | Host write strobe |
| host_file | input | 2 | File code: 0 index, 1 modify, 2 length |
| host_sel | input | 2 | Register number within the file |
| host_wdata | input | 14 | Host write data |
| host_rdata | output | 14 | Host read data (combinational) |

## Verification
An address is due exactly one cycle after the request edge. The driver pushes the address it predicts when it drives a request. The monitor pops and compares one entry each cycle in which `addr_valid` is high, sampling shortly after the edge. Register updates from requests and host writes are visible on the next edge, so every readback is sampled after that edge. Because `host_rdata` is combinational, it is sampled a short delay after the select is driven. The bench keeps its own model of all registers, computed from the requirements.

// File: rtl/dag_pkg.sv
package dag_pkg;
   typedef enum logic [1:0] {
      FILE_IDX  = 2'd0,
      FILE_MOD  = 2'd1,
      FILE_LEN  = 2'd2,
      FILE_NONE = 2'd3
   } reg_file_e;
endpackage

// File: rtl/dag_regfile.sv
module dag_regfile #(
   parameter int AW   = 14,
   parameter int NREG = 4,
   localparam int SW  = (NREG > 1) ? $clog2(NREG) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [SW-1:0]        wr_sel,
   input  logic [AW-1:0]        wr_data,
   input  logic                 upd_en,
   input  logic [SW-1:0]        upd_sel,
   input  logic [AW-1:0]        upd_data,
   output logic [NREG*AW-1:0]   q_flat
);
   for (genvar g = 0; g < NREG; g++) begin : g_reg
      logic [AW-1:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            q <= '0;
         else if (wr_en && wr_sel == SW'(g))
            q <= wr_data;
         else if (upd_en && upd_sel == SW'(g))
            q <= upd_data;
      end
      assign q_flat[g*AW +: AW] = q;
   end
endmodule

// File: rtl/dag_modulo.sv
module dag_modulo #(
   parameter int AW = 14
) (
   input  logic [AW-1:0] cur,
   input  logic [AW-1:0] mod,
   input  logic [AW-1:0] len,
   output logic [AW-1:0] nxt
);
   localparam int EW = AW + 2;

   logic [EW-1:0] len_x, blk, mask, base, top;
   logic signed [EW-1:0] sum;

   assign len_x = {2'b00, len};

   always_comb begin
      blk = '0;
      for (int j = 0; j <= AW; j++)
         if (blk == '0 && (EW'(1) << j) >= len_x)
            blk = EW'(1) << j;
   end

   assign mask = blk - EW'(1);
   assign base = {2'b00, cur} & ~mask;
   assign top  = base + len_x - EW'(1);
   assign sum  = $signed({2'b00, cur}) + $signed({{2{mod[AW-1]}}, mod});

   always_comb begin
      if (len == '0)
         nxt = sum[AW-1:0];
      else if (sum > $signed(top))
         nxt = AW'(sum - $signed(len_x));
      else if (sum < $signed(base))
         nxt = AW'(sum + $signed(len_x));
      else
         nxt = sum[AW-1:0];
   end

   logic [AW-1:0] m_mag;
   assign m_mag = mod[AW-1] ? AW'(-mod) : mod;

   always_comb begin
      if (!$isunknown({cur, mod, len}) && len != '0 &&
          {2'b00, cur} <= top && m_mag <= len)
         assert_wrap_in_buffer_R7: assert ({2'b00, nxt} >= base && {2'b00, nxt} <= top);
   end
endmodule

// File: rtl/dag_bitrev.sv
module dag_bitrev #(
   parameter int AW     = 14,
   parameter bit ENABLE = 1'b1
) (
   input  logic          en,
   input  logic [AW-1:0] a,
   output logic [AW-1:0] y
);
   if (ENABLE) begin : g_rev
      logic [AW-1:0] rev;
      for (genvar i = 0; i < AW; i++) begin : g_bit
         assign rev[i] = a[AW-1-i];
      end
      assign y = en ? rev : a;
   end else begin : g_pass
      logic unused_en;
      assign unused_en = en;
      assign y = a;
   end
endmodule

// File: rtl/dag_addr_gen.sv
module dag_addr_gen
   import dag_pkg::*;
#(
   parameter int AW      = 14,
   parameter int NREG    = 4,
   parameter bit BREV_ON = 1'b1,
   localparam int SW     = (NREG > 1) ? $clog2(NREG) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic [SW-1:0] req_isel,
   input  logic [SW-1:0] req_msel,
   input  logic          brev_en,
   output logic          addr_valid,
   output logic [AW-1:0] addr,
   input  logic          host_we,
   input  logic [1:0]    host_file,
   input  logic [SW-1:0] host_sel,
   input  logic [AW-1:0] host_wdata,
   output logic [AW-1:0] host_rdata
);
   if (AW < 2) begin : g_bad_aw
      $error("dag_addr_gen: AW must be at least 2");
   end
   if (NREG < 2 || (1 << SW) != NREG) begin : g_bad_nreg
      $error("dag_addr_gen: NREG must be a power of two >= 2");
   end

   logic [NREG*AW-1:0] i_all, m_all, l_all;
   logic [AW-1:0] cur_i, cur_m, cur_l, nxt_i, out_a;
   logic wr_i, wr_m, wr_l;

   assign wr_i = host_we && host_file == FILE_IDX;
   assign wr_m = host_we && host_file == FILE_MOD;
   assign wr_l = host_we && host_file == FILE_LEN;

   dag_regfile #(.AW(AW), .NREG(NREG)) u_irf (
      .clk, .rst_n, .wr_en(wr_i), .wr_sel(host_sel), .wr_data(host_wdata),
      .upd_en(req_valid), .upd_sel(req_isel), .upd_data(nxt_i), .q_flat(i_all));
   dag_regfile #(.AW(AW), .NREG(NREG)) u_mrf (
      .clk, .rst_n, .wr_en(wr_m), .wr_sel(host_sel), .wr_data(host_wdata),
      .upd_en(1'b0), .upd_sel('0), .upd_data('0), .q_flat(m_all));
   dag_regfile #(.AW(AW), .NREG(NREG)) u_lrf (
      .clk, .rst_n, .wr_en(wr_l), .wr_sel(host_sel), .wr_data(host_wdata),
      .upd_en(1'b0), .upd_sel('0), .upd_data('0), .q_flat(l_all));

   assign cur_i = i_all[req_isel*AW +: AW];
   assign cur_m = m_all[req_msel*AW +: AW];
   assign cur_l = l_all[req_isel*AW +: AW];

   dag_modulo #(.AW(AW)) u_mod (.cur(cur_i), .mod(cur_m), .len(cur_l), .nxt(nxt_i));
   dag_bitrev #(.AW(AW), .ENABLE(BREV_ON)) u_rev (.en(brev_en), .a(cur_i), .y(out_a));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_valid <= 1'b0;
         addr       <= '0;
      end else begin
         addr_valid <= req_valid;
         if (req_valid) addr <= out_a;
      end
   end

   always_comb begin
      unique case (host_file)
         FILE_IDX: host_rdata = i_all[host_sel*AW +: AW];
         FILE_MOD: host_rdata = m_all[host_sel*AW +: AW];
         FILE_LEN: host_rdata = l_all[host_sel*AW +: AW];
         default:  host_rdata = '0;
      endcase
   end

   logic collide;
   assign collide = wr_i && host_sel == req_isel;

   assert_addr_due_R3: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> addr_valid);
   assert_no_spurious_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !addr_valid);
   assert_old_index_R3: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !brev_en |=> addr == $past(cur_i));
   assert_linear_add_R6: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !collide && cur_l == '0 |=>
         i_all[$past(req_isel)*AW +: AW] == AW'($past(cur_i) + $past(cur_m)));
   assert_host_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && collide |=> i_all[$past(req_isel)*AW +: AW] == $past(host_wdata));
endmodule

// File: tb/tb_dag_addr_gen.sv
module tb_dag_addr_gen;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, brev_en = 1'b0, host_we = 1'b0;
   logic [1:0] req_isel = '0, req_msel = '0, host_file = '0, host_sel = '0;
   logic [13:0] host_wdata = '0;
   logic addr_valid;
   logic [13:0] addr, host_rdata;

   always #2.5 clk = ~clk;

   dag_addr_gen dut (.*);

   int checks = 0, errors = 0;
   logic [13:0] bi[4], bm[4], bl[4];
   logic [13:0] exp_q[$];
   string tag_q[$];

   function automatic logic [13:0] rev14(logic [13:0] a);
      for (int i = 0; i < 14; i++) rev14[i] = a[13-i];
   endfunction

   function automatic logic [13:0] model_next(logic [13:0] i, logic [13:0] m, logic [13:0] l);
      int s, base, sz;
      s = int'(i) + (m[13] ? int'(m) - 16384 : int'(m));
      if (l == 0) return 14'(s);
      sz = 1;
      while (sz < int'(l)) sz = sz * 2;
      base = int'(i) - (int'(i) % sz);
      if (s > base + int'(l) - 1) s = s - int'(l);
      else if (s < base) s = s + int'(l);
      return 14'(s);
   endfunction

   task automatic check(string tag, logic [13:0] act, logic [13:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic host_write(logic [1:0] f, logic [1:0] s, logic [13:0] d);
      @(negedge clk);
      req_valid = 1'b0; host_we = 1'b1; host_file = f; host_sel = s; host_wdata = d;
      @(posedge clk);
      if (f == 0) bi[s] = d; else if (f == 1) bm[s] = d; else if (f == 2) bl[s] = d;
   endtask

   task automatic host_check(string tag, logic [1:0] f, logic [1:0] s, logic [13:0] exp);
      @(negedge clk);
      req_valid = 1'b0; host_we = 1'b0; host_file = f; host_sel = s;
      #1 check(tag, host_rdata, exp);
   endtask

   task automatic do_req(string tag, logic [1:0] is, logic [1:0] ms, logic br);
      @(negedge clk);
      host_we = 1'b0; req_valid = 1'b1; req_isel = is; req_msel = ms; brev_en = br;
      exp_q.push_back(br ? rev14(bi[is]) : bi[is]);
      tag_q.push_back(tag);
      bi[is] = model_next(bi[is], bm[is == is ? ms : ms], bl[is]);
      @(posedge clk);
   endtask

   task automatic idle(int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         req_valid = 1'b0; host_we = 1'b0; brev_en = 1'b0;
      end
   endtask

   initial begin : monitor
      forever begin
         @(posedge clk); #1;
         if (rst_n && addr_valid) begin
            if (exp_q.size() == 0) begin
               checks++; errors++;
               $display("FAIL R3 unexpected address actual=%h expected=none", addr);
            end else begin
               automatic logic [13:0] e = exp_q.pop_front();
               automatic string t = tag_q.pop_front();
               check(t, addr, e);
            end
         end
      end
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : stim
      for (int k = 0; k < 4; k++) begin bi[k] = 0; bm[k] = 0; bl[k] = 0; end
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1 check("R1 addr_valid", {13'd0, addr_valid}, 14'd0);
      for (int f = 0; f < 3; f++)
         for (int s = 0; s < 4; s++)
            host_check("R1 reset reg", 2'(f), 2'(s), 14'd0);

      host_write(0, 0, 14'h0100);
      host_write(1, 0, 14'd4);
      host_write(1, 1, 14'h3FFE);
      host_write(3, 1, 14'h1234);
      host_check("R2 idx readback", 0, 0, 14'h0100);
      host_check("R2 mod readback", 1, 1, 14'h3FFE);
      host_check("R2 code3 reads zero", 3, 1, 14'd0);
      host_check("R2 code3 write ignored", 1, 1, 14'h3FFE);

      do_req("R3 R10 first", 0, 0, 0);
      do_req("R10 second", 0, 0, 0);
      do_req("R10 third", 0, 0, 0);
      do_req("R4 negative modify", 0, 1, 0);
      idle(1);
      host_check("R4 index after signed add", 0, 0, 14'h010A);
      host_check("R5 unselected index kept", 0, 1, 14'd0);
      do_req("R5 cross pairing", 1, 0, 0);
      idle(1);
      host_check("R5 index1 with modify0", 0, 1, 14'd4);

      host_write(0, 2, 14'h3FFE);
      host_write(1, 2, 14'd3);
      do_req("R6 linear near top", 2, 2, 0);
      idle(1);
      host_check("R6 wrap past 2^14", 0, 2, 14'd1);
      do_req("R6 linear down", 2, 1, 0);
      idle(1);
      host_check("R6 wrap below zero", 0, 2, 14'h3FFF);

      host_write(0, 3, 14'd35);
      host_write(2, 3, 14'd10);
      host_write(1, 3, 14'd5);
      for (int k = 0; k < 4; k++) do_req("R7 circular up", 3, 3, 0);
      idle(1);
      host_check("R7 index in buffer", 0, 3, bi[3]);
      host_write(1, 3, 14'h3FFD);
      for (int k = 0; k < 4; k++) do_req("R7 circular down", 3, 3, 0);
      idle(1);
      host_check("R7 index after down wrap", 0, 3, bi[3]);

      host_write(0, 0, 14'd1);
      do_req("R8 reversed address", 0, 0, 1);
      idle(1);
      host_check("R8 stored index not reversed", 0, 0, 14'd5);

      @(negedge clk);
      req_valid = 1'b1; req_isel = 0; req_msel = 0; brev_en = 1'b0;
      host_we = 1'b1; host_file = 0; host_sel = 0; host_wdata = 14'h0AAA;
      exp_q.push_back(bi[0]); tag_q.push_back("R9 address is old index");
      bi[0] = 14'h0AAA;
      @(posedge clk);
      idle(1);
      host_check("R9 host write wins", 0, 0, 14'h0AAA);

      idle(3);
      check("R3 all addresses seen", 14'(exp_q.size()), 14'd0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule